// File: doc/BRIEF.md
# Fused Two-Stage Integer Combine ALU

This unit executes one fused integer instruction per cycle in the form `result = op2(src3, op1(src1, src2))`. Two 4-bit operation selectors are taken from two opcode bytes. They pick from a 16-entry set of logic, arithmetic, shift, rotate, merge and field-extract operations. The first stage combines the first two sources. The second stage combines the third source, as its left operand, with the first stage's value, as its right operand. A single bit of the first opcode byte selects 64-bit or 32-bit operands. In 32-bit mode only the low halves of the sources are used, and the result is zero-extended.

The unit also decides whether the opcode pair is legal. The second opcode byte must be in its class range, reverse-subtract may not be the first operation, and the second operation is restricted unless the version input equals 1. An illegal instruction raises a flag and returns a zero result. Per-operand tag bits are merged into a result tag. The block is pipelined by one register stage, so each accepted instruction produces its result on the following cycle.

Top module: `icomb_alu`

## Requirements
- R1: An instruction presented with `in_valid` high at a rising edge appears on the outputs with `out_valid` high after exactly that edge. `out_valid` is low in cycles that follow an edge with `in_valid` low. While `in_valid` is low, the other outputs hold their values.
- R2: The first selector is `opc_a[4:1]`. The second selector is `{opc_b[1:0], opc_a[6:5]}`. `opc_a[0]`=1 selects 64-bit mode and 0 selects 32-bit mode. `opc_a[7]` is ignored.
- R3: The second stage takes `src3` as its left operand `a` and the first-stage value as its right operand `b`. Selector 6 (RSUB) yields `b - a`. Selector 9 (SUB) yields `a - b`, and selector 8 (ADD) yields `a + b`.
- R4: The logic selector codes are: 0 gives `a & b`, 1 gives `a & ~b`, 2 gives `a | b`, 3 gives `a | ~b`, 4 gives `a ^ b`, and 5 gives `a ^ ~b`.
- R5: The shift and rotate codes are: 10 rotates left, 11 rotates right, 12 is a logical left shift, 13 is a logical right shift, and 14 is an arithmetic right shift. Each shifts `a` by the low log2(width) bits of `b`.
- R6: Selector 7 (MERGE) yields `b` when `merge_cond` is 1 and `a` when it is 0.
- R7: Selector 15 (field extract) shifts `a` right by the low log2(width) bits of `b`. It then keeps the low `b[13:8]` bits of that value, or all bits when `b[13:8]` is at least the width.
- R8: An `opc_b` outside 0x08..0x0B raises `illegal`.
- R9: A first selector of 6 raises `illegal` in every version.
- R10: When `version` is 1, every second selector is legal. Otherwise a second selector of 7 or of 10 and above raises `illegal`.
- R11: When `illegal` is raised, `result` is zero.
- R12: `res_tag` is the bitwise OR of `tag1`, `tag2` and `tag3`.
- R13: In 32-bit mode, `result[63:32]` is zero, and the upper halves of the sources have no effect.
- R14: After reset, `out_valid`, `result`, `res_tag` and `illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| opc_a | input | 8 | First opcode byte (first selector, width bit, low half of second selector) |
| opc_b | input | 8 | Second opcode byte (class range, high half of second selector) |
| src1 | input | 64 | First-stage left operand |
| src2 | input | 64 | First-stage right operand |
| src3 | input | 64 | Second-stage left operand |
| tag1 | input | TAG_W | Tag of src1 |
| tag2 | input | TAG_W | Tag of src2 |
| tag3 | input | TAG_W | Tag of src3 |
| merge_cond | input | 1 | Condition bit used by MERGE |
| version | input | VER_W | Version input that controls second-stage legality |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Combined result |
| res_tag | output | TAG_W | Combined tag |
| illegal | output | 1 | Illegal-opcode flag |

## Verification
The assertions check the cycle relation between `in_valid` and `out_valid` on every cycle. They also check the zero result under `illegal`, the tag OR, zero upper bits in 32-bit mode, and the legality rules for the opcode range, for RSUB in the first stage and for the version-dependent second stage. Only the bench's scenarios can show the arithmetic correctness of each of the sixteen operations in both stages. These scenarios include the reversed operand order of the second stage, shift and rotate amounts that exceed the width, merge polarity and field-extract bounds. The bench compares each result against its own model, using directed cases and a random sweep over both versions and both widths.

// File: rtl/icomb_pkg.sv
package icomb_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_AND  = 4'd0,
    OP_ANDN = 4'd1,
    OP_OR   = 4'd2,
    OP_ORN  = 4'd3,
    OP_XOR  = 4'd4,
    OP_XORN = 4'd5,
    OP_RSUB = 4'd6,
    OP_MRG  = 4'd7,
    OP_ADD  = 4'd8,
    OP_SUB  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_SHL  = 4'd12,
    OP_SHR  = 4'd13,
    OP_SAR  = 4'd14,
    OP_XTR  = 4'd15
  } icomb_op_e;
endpackage

// File: rtl/icomb_decode.sv
module icomb_decode
  import icomb_pkg::*;
#(
  parameter int VER_W      = 4,
  parameter int FULL_VER   = 1,
  parameter int CLASS_LO   = 8,
  parameter int CLASS_HI   = 11
) (
  input  logic [7:0]       opc_a,
  input  logic [7:0]       opc_b,
  input  logic [VER_W-1:0] version,
  output icomb_op_e        sel1,
  output icomb_op_e        sel2,
  output logic             wide,
  output logic             bad
);
  logic class_ok;
  logic first_bad;
  logic second_bad;

  always_comb begin
    sel1 = icomb_op_e'(opc_a[4:1]);
    sel2 = icomb_op_e'({opc_b[1:0], opc_a[6:5]});
    wide = opc_a[0];
    class_ok   = (32'(opc_b) >= CLASS_LO) && (32'(opc_b) <= CLASS_HI);
    first_bad  = (sel1 == OP_RSUB);
    second_bad = (32'(version) != FULL_VER) &&
                 ((sel2 == OP_MRG) || (sel2 >= OP_ROL));
    bad = !class_ok || first_bad || second_bad;
  end
endmodule

// File: rtl/icomb_op_unit.sv
module icomb_op_unit
  import icomb_pkg::*;
#(
  parameter int W   = 64,
  parameter int LEN_LSB = 8,
  parameter int LEN_W   = 6
) (
  input  icomb_op_e    sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         mcond,
  output logic [W-1:0] y
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0]   amt;
  logic [SHW:0]     amt_c;
  logic [LEN_W-1:0] len;
  logic [W-1:0]     one_w;
  logic [W-1:0]     fmask;
  logic [W-1:0]     shifted;

  always_comb begin
    amt     = b[SHW-1:0];
    amt_c   = (SHW+1)'(W) - {1'b0, amt};
    len     = b[LEN_LSB +: LEN_W];
    one_w   = {{(W-1){1'b0}}, 1'b1};
    fmask   = ({1'b0, len} >= (LEN_W+1)'(W)) ? {W{1'b1}} : ((one_w << len) - one_w);
    shifted = a >> amt;
    unique case (sel)
      OP_AND:  y = a & b;
      OP_ANDN: y = a & ~b;
      OP_OR:   y = a | b;
      OP_ORN:  y = a | ~b;
      OP_XOR:  y = a ^ b;
      OP_XORN: y = a ^ ~b;
      OP_RSUB: y = b - a;
      OP_MRG:  y = mcond ? b : a;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_ROL:  y = (a << amt) | (a >> amt_c);
      OP_ROR:  y = (a >> amt) | (a << amt_c);
      OP_SHL:  y = a << amt;
      OP_SHR:  y = shifted;
      OP_SAR:  y = W'($signed(a) >>> amt);
      OP_XTR:  y = shifted & fmask;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/icomb_alu.sv
module icomb_alu
  import icomb_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int TAG_W    = 2,
  parameter int VER_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opc_a,
  input  logic [7:0]        opc_b,
  input  logic [WIDE_W-1:0] src1,
  input  logic [WIDE_W-1:0] src2,
  input  logic [WIDE_W-1:0] src3,
  input  logic [TAG_W-1:0]  tag1,
  input  logic [TAG_W-1:0]  tag2,
  input  logic [TAG_W-1:0]  tag3,
  input  logic              merge_cond,
  input  logic [VER_W-1:0]  version,
  output logic              out_valid,
  output logic [WIDE_W-1:0] result,
  output logic [TAG_W-1:0]  res_tag,
  output logic              illegal
);
  localparam int NLANE = 2;

  icomb_op_e sel1, sel2;
  logic      wide, bad;
  logic [WIDE_W-1:0] lane_res [NLANE];
  logic [WIDE_W-1:0] pick;

  icomb_decode #(.VER_W(VER_W)) u_dec (
    .opc_a(opc_a), .opc_b(opc_b), .version(version),
    .sel1(sel1), .sel2(sel2), .wide(wide), .bad(bad)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] mid, fin;

    icomb_op_unit #(.W(LW)) u_st1 (
      .sel(sel1), .a(src1[LW-1:0]), .b(src2[LW-1:0]),
      .mcond(merge_cond), .y(mid)
    );
    icomb_op_unit #(.W(LW)) u_st2 (
      .sel(sel2), .a(src3[LW-1:0]), .b(mid),
      .mcond(merge_cond), .y(fin)
    );
    assign lane_res[g] = WIDE_W'(fin);
  end

  assign pick = wide ? lane_res[1] : lane_res[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      res_tag   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= bad ? '0 : pick;
        res_tag <= tag1 | tag2 | tag3;
        illegal <= bad;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result) && $stable(illegal)); // R1
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal |-> result == '0); // R11
  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opc_b < 8'h08 || opc_b > 8'h0B) |=> illegal); // R8
  AST_RSUB_FIRST: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc_a[4:1] == 4'd6 |=> illegal); // R9
  AST_VER_FULL: assert property (@(posedge clk) disable iff (rst)
    in_valid && version == VER_W'(1) && opc_b[7:2] == 6'b000010 &&
    opc_a[4:1] != 4'd6 |=> !illegal); // R10
  AST_VER_LIMIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && version != VER_W'(1) &&
    ({opc_b[1:0], opc_a[6:5]} >= 4'd10 || {opc_b[1:0], opc_a[6:5]} == 4'd7)
    |=> illegal); // R10
  AST_TAG_OR: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_tag == $past(tag1 | tag2 | tag3)); // R12
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !opc_a[0] |=> result[WIDE_W-1:NARROW_W] == '0); // R13
endmodule

// File: tb/sim_icomb_alu.sv
`timescale 1ns/1ps
module sim_icomb_alu;
  localparam int TAG_W = 2;
  localparam int VER_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] opc_a = '0, opc_b = '0;
  logic [63:0] src1 = '0, src2 = '0, src3 = '0;
  logic [TAG_W-1:0] tag1 = '0, tag2 = '0, tag3 = '0;
  logic merge_cond = 1'b0;
  logic [VER_W-1:0] version = '0;
  logic out_valid;
  logic [63:0] result;
  logic [TAG_W-1:0] res_tag;
  logic illegal;

  always #4 clk = ~clk;

  icomb_alu #(.TAG_W(TAG_W), .VER_W(VER_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opc_a(opc_a), .opc_b(opc_b),
    .src1(src1), .src2(src2), .src3(src3), .tag1(tag1), .tag2(tag2), .tag3(tag3),
    .merge_cond(merge_cond), .version(version),
    .out_valid(out_valid), .result(result), .res_tag(res_tag), .illegal(illegal)
  );

  typedef struct {
    logic [63:0]      res;
    logic [TAG_W-1:0] tag;
    logic             ill;
    string            req;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int issued = 0;
  int seen = 0;
  bit done = 0;

  function automatic logic [63:0] ref_op(int sel, logic [63:0] ai, logic [63:0] bi,
                                         bit w, bit mc);
    int wd = w ? 64 : 32;
    logic [63:0] m = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    logic [63:0] a = ai & m;
    logic [63:0] b = bi & m;
    int n = int'(b[5:0]) & (wd - 1);
    int len = int'(b[13:8]);
    logic [63:0] r;
    case (sel)
      0: r = a & b;
      1: r = a & ~b;
      2: r = a | b;
      3: r = a | ~b;
      4: r = a ^ b;
      5: r = a ^ ~b;
      6: r = b - a;
      7: r = mc ? b : a;
      8: r = a + b;
      9: r = a - b;
      10: begin
        r = a;
        for (int i = 0; i < n; i++) r = ((r << 1) | (r >> (wd - 1))) & m;
      end
      11: begin
        r = a;
        for (int i = 0; i < n; i++) r = (r >> 1) | ((r & 64'd1) << (wd - 1));
      end
      12: r = a << n;
      13: r = a >> n;
      14: begin
        r = a;
        for (int i = 0; i < n; i++) r = (r >> 1) | (r & (64'd1 << (wd - 1)));
      end
      default: begin
        r = a >> n;
        for (int i = 0; i < 64; i++) if (i >= len && i < wd) r[i] = 1'b0;
      end
    endcase
    return r & m;
  endfunction

  task automatic issue(input logic [7:0] oa, input logic [7:0] ob,
                       input logic [63:0] s1, input logic [63:0] s2, input logic [63:0] s3,
                       input logic [TAG_W-1:0] t1, input logic [TAG_W-1:0] t2,
                       input logic [TAG_W-1:0] t3, input bit mc, input int ver,
                       input string req);
    int k1 = int'(oa[4:1]);
    int k2 = int'({ob[1:0], oa[6:5]});
    bit w = oa[0];
    bit ill;
    logic [63:0] mid;
    exp_t e;
    ill = (ob < 8'h08) || (ob > 8'h0B) || (k1 == 6) ||
          (ver != 1 && (k2 == 7 || k2 >= 10));
    mid = ref_op(k1, s1, s2, w, mc);
    e.res = ill ? 64'd0 : ref_op(k2, s3, mid, w, mc);
    e.tag = t1 | t2 | t3;
    e.ill = ill;
    e.req = req;
    @(negedge clk);
    in_valid = 1'b1; opc_a = oa; opc_b = ob;
    src1 = s1; src2 = s2; src3 = s3;
    tag1 = t1; tag2 = t2; tag3 = t3;
    merge_cond = mc; version = VER_W'(ver);
    sb.push_back(e);
    issued++;
  endtask

  function automatic logic [7:0] mk_a(int k1, int k2, bit w);
    return {1'b0, 2'(k2), 4'(k1), w};
  endfunction
  function automatic logic [7:0] mk_b(int k2);
    return 8'h08 | 8'(k2 >> 2);
  endfunction

  task automatic op(int k1, int k2, bit w, logic [63:0] s1, logic [63:0] s2,
                    logic [63:0] s3, bit mc, int ver, string req);
    issue(mk_a(k1, k2, w), mk_b(k2), s1, s2, s3, 2'b00, 2'b00, 2'b00, mc, ver, req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        seen++;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected out_valid, got result %h expected none", result);
        end else begin
          e = sb.pop_front();
          if (result !== e.res || res_tag !== e.tag || illegal !== e.ill) begin
            errors++;
            $display("FAIL %s: result %h tag %b ill %b, expected %h %b %b",
                     e.req, result, res_tag, illegal, e.res, e.tag, e.ill);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(8ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || res_tag !== '0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R14: after reset v=%b r=%h t=%b i=%b, expected all zero",
               out_valid, result, res_tag, illegal);
    end

    // R4 logic codes, second stage OR with zero src3 passes stage one through
    for (int k = 0; k < 6; k++)
      op(k, 2, 1, 64'hF0F0_1234_AAAA_5555, 64'hFF00_00FF_0F0F_3C3C, 64'd0, 0, 0, "R4");
    // R3 ordering: second-stage SUB and RSUB, first-stage ADD/SUB
    op(8, 9, 1, 64'd100, 64'd23, 64'd1000, 0, 0, "R3");
    op(9, 6, 1, 64'd100, 64'd23, 64'd1000, 0, 0, "R3");
    op(8, 8, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd5, 0, 0, "R3");
    // R5 shifts and rotates, amounts beyond width, both widths
    for (int k = 10; k < 15; k++) begin
      op(k, 0, 1, 64'h8123_4567_89AB_CDEF, 64'd70, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5");
      op(k, 0, 0, 64'h0000_0000_8765_4321, 64'd37, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5");
    end
    // R6 merge polarity in stage one and stage two
    op(7, 0, 1, 64'h1111, 64'h2222, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R6");
    op(7, 0, 1, 64'h1111, 64'h2222, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R6");
    op(2, 7, 1, 64'h3300, 64'h0044, 64'h5555, 1, 1, "R6");
    op(2, 7, 1, 64'h3300, 64'h0044, 64'h5555, 0, 1, "R6");
    // R7 field extract: offset 8 length 12; length beyond width; length zero
    op(15, 0, 1, 64'h0123_4567_89AB_CDEF, 64'h0C08, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R7");
    op(15, 0, 0, 64'hDEAD_BEEF_CAFE_F00D, 64'h3F04, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R7");
    op(15, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0003, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R7");
    // R8 class range
    issue(mk_a(8, 0, 1), 8'h07, 64'd1, 64'd2, 64'd3, 2'b01, 2'b00, 2'b00, 0, 1, "R8");
    issue(mk_a(8, 0, 1), 8'h0C, 64'd1, 64'd2, 64'd3, 2'b00, 2'b10, 2'b00, 0, 1, "R8");
    // R9 RSUB first, both versions
    op(6, 0, 1, 64'd5, 64'd9, 64'd7, 0, 1, "R9");
    op(6, 0, 1, 64'd5, 64'd9, 64'd7, 0, 0, "R9");
    // R10 version rule
    op(8, 7, 1, 64'd5, 64'd9, 64'd7, 1, 0, "R10");
    op(8, 10, 1, 64'd5, 64'd9, 64'd7, 0, 2, "R10");
    op(8, 15, 1, 64'd5, 64'd9, 64'd7, 0, 0, "R10");
    op(8, 9, 1, 64'd5, 64'd9, 64'd7, 0, 0, "R10");
    op(8, 15, 1, 64'h10, 64'h0408, 64'hABCD_EF01, 0, 1, "R10");
    op(8, 12, 0, 64'd3, 64'd1, 64'h1, 0, 1, "R10");
    // R2 ignored top bit of opc_a
    issue(mk_a(4, 3, 1) | 8'h80, mk_b(3), 64'hAA, 64'h0F, 64'h100, 0, 0, 0, 0, 0, "R2");
    // R11 illegal zeroes result even with large operands
    op(6, 2, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R11");
    // R12 tags
    issue(mk_a(0, 0, 1), mk_b(0), 64'd1, 64'd1, 64'd1, 2'b01, 2'b00, 2'b00, 0, 0, "R12");
    issue(mk_a(0, 0, 1), mk_b(0), 64'd1, 64'd1, 64'd1, 2'b00, 2'b10, 2'b01, 0, 0, "R12");
    // R13 narrow mode ignores upper halves
    op(8, 8, 0, 64'hFFFF_0000_8000_0000, 64'hABCD_0000_8000_0000, 64'h7777_0000_0000_0001,
       0, 0, "R13");
    // R1 bubbles: outputs hold while idle
    idle(3);
    op(4, 4, 1, 64'h55, 64'hAA, 64'h0F, 0, 0, "R1");
    idle(2);
    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [7:0] oa, ob;
      oa = 8'($urandom);
      ob = ((i % 9) == 0) ? 8'($urandom) : (8'h08 | 8'($urandom % 4));
      issue(oa, ob, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 3),
            "R3");
      if ((i % 17) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb.size() != 0 || seen != issued) begin
      errors++;
      $display("FAIL R1: results seen %0d, expected %0d", seen, issued);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule